// File: doc/BRIEF.md
# Multi-Channel Converter Scan Sequencer with Threshold Crossing Detect

This block drives an external analog-to-digital converter through a simple sample/done handshake. It walks a programmed list of channel numbers with no processor involvement. For each list entry it holds a sample request for a programmed number of clocks. It then waits for the converter's done pulse and for a programmed minimum conversion time. It corrects the raw 10-bit code by a stored zero offset, narrows it to 8 bits when asked, and writes the value into a result register owned by that channel.

A threshold mode keeps, for each channel, whether its last result was at or above a programmable level. When a new result lands on the other side of that level, the block pulses an interrupt that carries the channel and the direction of the crossing. A scan can run once or repeat. A sticky completion flag marks the end of each pass through the list. All configuration inputs are expected to stay stable while a scan is busy.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, all result registers and valid bits are zero, and `busy`, `scan_done`, `conv_sample` and `thr_irq` are low.
- R2: A `scan_go` pulse while idle converts list entries 0 up to `list_len`-1 in order, presenting each entry on `conv_chan`. Each entry occupies bits [3i+2:3i] of `list_chan` for the bench width. A length of zero acts as one, and a length above the list depth acts as the depth. Each result is written to `result_flat[10c+9:10c]` for channel c, and `result_valid[c]` is set.
- R3: `conv_sample` stays high for exactly `sample_clks` consecutive cycles per conversion, or for one cycle when `sample_clks` is zero.
- R4: After the sample phase, the conversion phase lasts max(`convert_clks`, cycle of the `conv_done` pulse, 1) cycles. One store cycle follows before the next sample phase.
- R5: The stored value is raw minus `zero_off`, clamped at zero when the offset is larger than the raw code.
- R6: With `res8` high, the stored value is the offset-corrected code shifted right by two, so the result is 8 bits wide with zeros above. With `res8` low, it is the full 10 bits.
- R7: With `thr_en` high, a result is "above" when it is greater than or equal to `thresh`. In 8-bit mode the comparison uses `thresh` shifted right by two. When a channel's above state changes, `thr_irq` pulses for one cycle, `thr_chan` gives the channel, and `thr_dir` is 1 for a rising crossing and 0 for a falling one. With `thr_en` low, no interrupt occurs.
- R8: The first result of a channel after `thr_en` goes high only records its above state and raises no interrupt.
- R9: `scan_done` clears when a scan starts. It sets after the last list entry is stored. `busy` is high from the cycle after `scan_go` until the scan ends.
- R10: With `continuous` high, the conversion after the last entry uses list entry 0 again. Lowering `continuous` stops the scan at the end of the pass in progress.
- R11: A `scan_go` pulse while busy is ignored, and the scan performs exactly its programmed number of conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_go | input | 1 | Start pulse, honoured only while idle |
| continuous | input | 1 | Repeat the list until lowered |
| res8 | input | 1 | 1 selects 8-bit results, 0 selects 10-bit |
| sample_clks | input | CNTW | Sample phase length in clocks |
| convert_clks | input | CNTW | Minimum conversion phase length in clocks |
| list_len | input | $clog2(LIST_LEN+1) | Number of list entries to convert |
| list_chan | input | LIST_LEN*$clog2(NCH) | Packed channel list, entry 0 in the low bits |
| zero_off | input | 10 | Zero offset subtracted from raw codes |
| thr_en | input | 1 | Threshold crossing detection enable |
| thresh | input | 10 | Threshold level in 10-bit units |
| conv_sample | output | 1 | Sample request to the converter |
| conv_chan | output | $clog2(NCH) | Channel being converted |
| conv_done | input | 1 | One-cycle done pulse from the converter |
| conv_data | input | 10 | Raw code, valid with conv_done |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Sticky end-of-pass flag |
| result_flat | output | NCH*10 | Per-channel result registers |
| result_valid | output | NCH | Per-channel written flags |
| thr_irq | output | 1 | One-cycle crossing interrupt |
| thr_chan | output | $clog2(NCH) | Channel of the crossing |
| thr_dir | output | 1 | 1 rising, 0 falling crossing |

## Verification
The bench builds the block with eight channels, a list depth of six and 4-bit timing counters. The list depth that is not a power of two makes the length clamp and the zero-length case reachable. The narrow counters let both the minimum and the maximum sample and conversion lengths be tried in a short run. The converter model replies after one to six cycles, both before and after the programmed conversion count, so each side of the "whichever is later" rule decides some conversions.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   localparam int unsigned SMP_W = 10;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SAMPLE  = 2'd1,
      ST_CONVERT = 2'd2,
      ST_STORE   = 2'd3
   } seq_state_t;

   // raw code minus offset, clamped at zero
   function automatic logic [SMP_W-1:0] offset_fix(input logic [SMP_W-1:0] raw,
                                                   input logic [SMP_W-1:0] off);
      offset_fix = (raw > off) ? (raw - off) : '0;
   endfunction

   // narrow to 8 significant bits when requested
   function automatic logic [SMP_W-1:0] fit_res(input logic [SMP_W-1:0] v,
                                                input logic narrow);
      fit_res = narrow ? {2'b00, v[SMP_W-1:2]} : v;
   endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_scan_pkg::*;
#(
   parameter int unsigned NCH      = 8,
   parameter int unsigned LIST_LEN = 8,
   parameter int unsigned CNTW     = 8,
   localparam int unsigned CHW     = $clog2(NCH),
   localparam int unsigned IW      = $clog2(LIST_LEN),
   localparam int unsigned LLW     = $clog2(LIST_LEN + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scan_go,
   input  logic                    continuous,
   input  logic [CNTW-1:0]         sample_clks,
   input  logic [CNTW-1:0]         convert_clks,
   input  logic [LLW-1:0]          list_len,
   input  logic [LIST_LEN*CHW-1:0] list_chan,
   input  logic                    conv_done,
   input  logic [SMP_W-1:0]        conv_data,
   output logic                    conv_sample,
   output logic [CHW-1:0]          conv_chan,
   output logic                    busy,
   output logic                    scan_done,
   output logic                    store_stb,
   output logic [CHW-1:0]          store_ch,
   output logic [SMP_W-1:0]        store_raw
);

   if (LIST_LEN < 2) begin : g_bad_list
      $error("adc_seq_ctrl: LIST_LEN must be at least 2");
   end
   if (CNTW < 1) begin : g_bad_cnt
      $error("adc_seq_ctrl: CNTW must be at least 1");
   end

   seq_state_t       state;
   logic [IW-1:0]    idx;
   logic [CNTW-1:0]  cnt;
   logic             done_seen;
   logic [SMP_W-1:0] raw_q;

   logic [CHW-1:0]   entry [LIST_LEN];

   for (genvar g = 0; g < LIST_LEN; g++) begin : g_unpack
      assign entry[g] = list_chan[g*CHW +: CHW];
   end

   logic [CNTW:0] cnt_inc;
   logic          sample_hit;
   logic          conv_hit;
   logic          have_done;
   logic [LLW:0]  idx_inc;
   logic          last_entry;

   always_comb begin
      cnt_inc    = {1'b0, cnt} + (CNTW+1)'(1);
      sample_hit = cnt_inc >= {1'b0, sample_clks};
      conv_hit   = cnt_inc >= {1'b0, convert_clks};
      have_done  = done_seen | conv_done;
      idx_inc    = {{(LLW+1-IW){1'b0}}, idx} + (LLW+1)'(1);
      last_entry = (idx_inc >= {1'b0, list_len}) || (idx == IW'(LIST_LEN - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx       <= '0;
         cnt       <= '0;
         done_seen <= 1'b0;
         raw_q     <= '0;
         scan_done <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (scan_go) begin
                  state     <= ST_SAMPLE;
                  idx       <= '0;
                  cnt       <= '0;
                  scan_done <= 1'b0;
               end
            end
            ST_SAMPLE: begin
               if (sample_hit) begin
                  state     <= ST_CONVERT;
                  cnt       <= '0;
                  done_seen <= 1'b0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CONVERT: begin
               if (conv_done) begin
                  raw_q     <= conv_data;
                  done_seen <= 1'b1;
               end
               if (conv_hit && have_done) begin
                  state <= ST_STORE;
               end else if (!conv_hit) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STORE: begin
               cnt <= '0;
               if (last_entry) begin
                  scan_done <= 1'b1;
                  idx       <= '0;
                  state     <= continuous ? ST_SAMPLE : ST_IDLE;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= ST_SAMPLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign conv_sample = (state == ST_SAMPLE);
   assign conv_chan   = entry[idx];
   assign busy        = (state != ST_IDLE);
   assign store_stb   = (state == ST_STORE);
   assign store_ch    = entry[idx];
   assign store_raw   = raw_q;

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
   import adc_scan_pkg::*;
#(
   parameter int unsigned NCH  = 8,
   localparam int unsigned CHW = $clog2(NCH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 store_stb,
   input  logic [CHW-1:0]       store_ch,
   input  logic [SMP_W-1:0]     store_raw,
   input  logic [SMP_W-1:0]     zero_off,
   input  logic                 res8,
   output logic [NCH*SMP_W-1:0] result_flat,
   output logic [NCH-1:0]       result_valid,
   output logic [SMP_W-1:0]     fixed_val
);

   if (NCH < 2) begin : g_bad_nch
      $error("adc_result_bank: NCH must be at least 2");
   end

   assign fixed_val = fit_res(offset_fix(store_raw, zero_off), res8);

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic hit;
      assign hit = store_stb && (store_ch == CHW'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            result_flat[g*SMP_W +: SMP_W] <= '0;
            result_valid[g]               <= 1'b0;
         end else if (hit) begin
            result_flat[g*SMP_W +: SMP_W] <= fixed_val;
            result_valid[g]               <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/adc_thresh_track.sv
module adc_thresh_track
   import adc_scan_pkg::*;
#(
   parameter int unsigned NCH  = 8,
   localparam int unsigned CHW = $clog2(NCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thr_en,
   input  logic [SMP_W-1:0] thresh,
   input  logic             res8,
   input  logic             upd_stb,
   input  logic [CHW-1:0]   upd_ch,
   input  logic [SMP_W-1:0] upd_val,
   output logic             thr_irq,
   output logic [CHW-1:0]   thr_chan,
   output logic             thr_dir
);

   logic [NCH-1:0]   ref_ok;
   logic [NCH-1:0]   above_q;
   logic [SMP_W-1:0] level;
   logic             now_above;

   always_comb begin
      level     = fit_res(thresh, res8);
      now_above = (upd_val >= level);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_ok   <= '0;
         above_q  <= '0;
         thr_irq  <= 1'b0;
         thr_chan <= '0;
         thr_dir  <= 1'b0;
      end else if (!thr_en) begin
         ref_ok  <= '0;
         thr_irq <= 1'b0;
      end else if (upd_stb) begin
         ref_ok[upd_ch]  <= 1'b1;
         above_q[upd_ch] <= now_above;
         thr_irq         <= ref_ok[upd_ch] && (above_q[upd_ch] != now_above);
         thr_chan        <= upd_ch;
         thr_dir         <= now_above;
      end else begin
         thr_irq <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int unsigned NCH      = 8,
   parameter int unsigned LIST_LEN = 8,
   parameter int unsigned CNTW     = 8,
   localparam int unsigned CHW     = $clog2(NCH),
   localparam int unsigned LLW     = $clog2(LIST_LEN + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scan_go,
   input  logic                    continuous,
   input  logic                    res8,
   input  logic [CNTW-1:0]         sample_clks,
   input  logic [CNTW-1:0]         convert_clks,
   input  logic [LLW-1:0]          list_len,
   input  logic [LIST_LEN*CHW-1:0] list_chan,
   input  logic [SMP_W-1:0]        zero_off,
   input  logic                    thr_en,
   input  logic [SMP_W-1:0]        thresh,
   output logic                    conv_sample,
   output logic [CHW-1:0]          conv_chan,
   input  logic                    conv_done,
   input  logic [SMP_W-1:0]        conv_data,
   output logic                    busy,
   output logic                    scan_done,
   output logic [NCH*SMP_W-1:0]    result_flat,
   output logic [NCH-1:0]          result_valid,
   output logic                    thr_irq,
   output logic [CHW-1:0]          thr_chan,
   output logic                    thr_dir
);

   logic             store_stb;
   logic [CHW-1:0]   store_ch;
   logic [SMP_W-1:0] store_raw;
   logic [SMP_W-1:0] fixed_val;

   adc_seq_ctrl #(
      .NCH      (NCH),
      .LIST_LEN (LIST_LEN),
      .CNTW     (CNTW)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .scan_go      (scan_go),
      .continuous   (continuous),
      .sample_clks  (sample_clks),
      .convert_clks (convert_clks),
      .list_len     (list_len),
      .list_chan    (list_chan),
      .conv_done    (conv_done),
      .conv_data    (conv_data),
      .conv_sample  (conv_sample),
      .conv_chan    (conv_chan),
      .busy         (busy),
      .scan_done    (scan_done),
      .store_stb    (store_stb),
      .store_ch     (store_ch),
      .store_raw    (store_raw)
   );

   adc_result_bank #(
      .NCH (NCH)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .store_stb    (store_stb),
      .store_ch     (store_ch),
      .store_raw    (store_raw),
      .zero_off     (zero_off),
      .res8         (res8),
      .result_flat  (result_flat),
      .result_valid (result_valid),
      .fixed_val    (fixed_val)
   );

   adc_thresh_track #(
      .NCH (NCH)
   ) u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .thr_en   (thr_en),
      .thresh   (thresh),
      .res8     (res8),
      .upd_stb  (store_stb),
      .upd_ch   (store_ch),
      .upd_val  (fixed_val),
      .thr_irq  (thr_irq),
      .thr_chan (thr_chan),
      .thr_dir  (thr_dir)
   );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
   parameter int unsigned NCH  = 8,
   parameter int unsigned CNTW = 8,
   localparam int unsigned CHW = $clog2(NCH)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_sample,
   input logic [CNTW-1:0] sample_clks,
   input logic            busy,
   input logic            thr_irq,
   input logic            thr_en,
   input logic [CHW-1:0]  thr_chan,
   input logic [NCH-1:0]  result_valid
);

   logic [CNTW:0] high_run;
   logic [CNTW:0] smin;

   assign smin = (sample_clks == '0) ? (CNTW+1)'(1) : {1'b0, sample_clks};

   always_ff @(posedge clk) begin
      if (!rst_n) high_run <= '0;
      else if (conv_sample) high_run <= high_run + 1'b1;
      else high_run <= '0;
   end

   // R3: sample request never outlasts its programmed length
   a_r3_sample_bound: assert property (@(posedge clk) disable iff (!rst_n)
      conv_sample |-> (high_run < smin));

   // R3: sample request never ends early
   a_r3_sample_full: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conv_sample) |-> (high_run == smin));

   // R9: no sample request while the sequencer is idle
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !conv_sample);

   // R7: interrupt only follows a cycle with the mode enabled
   a_r7_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
      thr_irq |-> $past(thr_en));

   // R7: the reported channel holds a written result
   a_r7_irq_chan_valid: assert property (@(posedge clk) disable iff (!rst_n)
      thr_irq |-> result_valid[thr_chan]);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
   .NCH  (NCH),
   .CNTW (CNTW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_sample  (conv_sample),
   .sample_clks  (sample_clks),
   .busy         (busy),
   .thr_irq      (thr_irq),
   .thr_en       (thr_en),
   .thr_chan     (thr_chan),
   .result_valid (result_valid)
);

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;

   localparam int NCH = 8;
   localparam int LIST_LEN = 6;
   localparam int CNTW = 4;
   localparam int CHW = 3;
   localparam int LLW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scan_go = 1'b0;
   logic continuous = 1'b0;
   logic res8 = 1'b0;
   logic [CNTW-1:0] sample_clks = '0;
   logic [CNTW-1:0] convert_clks = '0;
   logic [LLW-1:0] list_len = '0;
   logic [LIST_LEN*CHW-1:0] list_chan = '0;
   logic [9:0] zero_off = '0;
   logic thr_en = 1'b0;
   logic [9:0] thresh = '0;
   logic conv_sample;
   logic [CHW-1:0] conv_chan;
   logic conv_done = 1'b0;
   logic [9:0] conv_data = '0;
   logic busy, scan_done;
   logic [NCH*10-1:0] result_flat;
   logic [NCH-1:0] result_valid;
   logic thr_irq;
   logic [CHW-1:0] thr_chan;
   logic thr_dir;

   always #4 clk = ~clk;

   adc_scan_seq #(.NCH(NCH), .LIST_LEN(LIST_LEN), .CNTW(CNTW)) u_dut (
      .clk(clk), .rst_n(rst_n), .scan_go(scan_go), .continuous(continuous),
      .res8(res8), .sample_clks(sample_clks), .convert_clks(convert_clks),
      .list_len(list_len), .list_chan(list_chan), .zero_off(zero_off),
      .thr_en(thr_en), .thresh(thresh), .conv_sample(conv_sample),
      .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
      .busy(busy), .scan_done(scan_done), .result_flat(result_flat),
      .result_valid(result_valid), .thr_irq(thr_irq), .thr_chan(thr_chan),
      .thr_dir(thr_dir));

   int n_chk = 0;
   int n_err = 0;
   int S = 0, C = 0, D = 1;
   logic [9:0] cdata [NCH];
   logic [9:0] exp_res [NCH];
   bit exp_val [NCH];
   bit tref [NCH];
   bit tab [NCH];
   int ent [LIST_LEN];
   int exp_ich [64];
   int exp_idir [64];
   int n_exp = 0;
   int obs_ich [64];
   int obs_idir [64];
   int n_irq = 0;
   int seq [64];
   int n_conv = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic finish_up();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   function automatic logic [9:0] exp_fix(input logic [9:0] raw, input logic [9:0] off, input bit r8);
      logic [9:0] t;
      t = (raw > off) ? raw - off : 10'd0;
      return r8 ? (t >> 2) : t;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // converter model and protocol monitor
   initial begin
      bit prev_s = 0;
      int cd = 0;
      int srun = 0;
      int lrun = 0;
      bit gap_ok = 0;
      forever begin
         @(negedge clk);
         if (prev_s && !conv_sample) cd = D;
         if (cd > 0) begin
            conv_done = (cd == 1);
            if (cd == 1) conv_data = cdata[conv_chan];
            cd--;
         end else begin
            conv_done = 1'b0;
         end
         if (conv_sample) srun++;
         if (prev_s && !conv_sample) begin
            chk(srun == imax(S, 1), "R3 sample length", srun, imax(S, 1));
            srun = 0;
            lrun = 1;
            gap_ok = 1;
         end else if (!conv_sample) begin
            lrun++;
         end
         if (!prev_s && conv_sample) begin
            if (gap_ok && busy)
               chk(lrun == imax(imax(C, 1), D) + 1, "R4 convert+store length",
                   lrun, imax(imax(C, 1), D) + 1);
            if (n_conv < 64) seq[n_conv] = int'(conv_chan);
            n_conv++;
         end
         if (!busy) gap_ok = 0;
         if (thr_irq) begin
            if (n_irq < 64) begin
               obs_ich[n_irq] = int'(thr_chan);
               obs_idir[n_irq] = int'(thr_dir);
            end
            n_irq++;
         end
         prev_s = conv_sample;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finish_up();
   end

   task automatic load_list(input int len);
      list_len = LLW'(len);
      for (int i = 0; i < LIST_LEN; i++) list_chan[i*CHW +: CHW] = CHW'(ent[i]);
   endtask

   task automatic set_thr(input bit en);
      thr_en = en;
      if (!en) for (int c = 0; c < NCH; c++) tref[c] = 0;
      @(negedge clk);
   endtask

   // expected effect of one pass through the list
   task automatic model_pass(input int len_eff);
      for (int i = 0; i < len_eff; i++) begin
         int ch;
         logic [9:0] v;
         bit a;
         ch = ent[i];
         v = exp_fix(cdata[ch], zero_off, res8);
         exp_res[ch] = v;
         exp_val[ch] = 1;
         if (thr_en) begin
            a = (v >= (res8 ? (thresh >> 2) : thresh));
            if (tref[ch] && (tab[ch] != a)) begin
               exp_ich[n_exp] = ch;
               exp_idir[n_exp] = a;
               n_exp++;
            end
            tref[ch] = 1;
            tab[ch] = a;
         end
      end
   endtask

   task automatic check_results(input string tag);
      for (int c = 0; c < NCH; c++) begin
         chk(result_flat[c*10 +: 10] == exp_res[c], tag,
             int'(result_flat[c*10 +: 10]), int'(exp_res[c]));
         chk(result_valid[c] == exp_val[c], "R2 valid bit", int'(result_valid[c]), int'(exp_val[c]));
      end
   endtask

   task automatic run_scan(input int len, input bit dup_go, input string tag);
      int len_eff;
      int guard;
      len_eff = (len == 0) ? 1 : ((len > LIST_LEN) ? LIST_LEN : len);
      load_list(len);
      n_exp = 0;
      model_pass(len_eff);
      n_conv = 0;
      n_irq = 0;
      @(negedge clk);
      scan_go = 1'b1;
      @(negedge clk);
      scan_go = 1'b0;
      chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
      chk(scan_done == 1'b0, "R9 done cleared at start", int'(scan_done), 0);
      if (dup_go) begin
         repeat (3) @(negedge clk);
         scan_go = 1'b1;
         @(negedge clk);
         scan_go = 1'b0;
      end
      guard = 0;
      while (busy && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (2) @(negedge clk);
      chk(n_conv == len_eff, dup_go ? "R11 conversions with extra go" : "R2 conversion count",
          n_conv, len_eff);
      for (int i = 0; i < len_eff && i < n_conv; i++)
         chk(seq[i] == ent[i], "R2 list order", seq[i], ent[i]);
      chk(scan_done == 1'b1, "R9 done after last entry", int'(scan_done), 1);
      check_results(tag);
      chk(n_irq == n_exp, "R7 interrupt count", n_irq, n_exp);
      for (int i = 0; i < n_exp && i < n_irq; i++) begin
         chk(obs_ich[i] == exp_ich[i], "R7 interrupt channel", obs_ich[i], exp_ich[i]);
         chk(obs_idir[i] == exp_idir[i], "R7 interrupt direction", obs_idir[i], exp_idir[i]);
      end
   endtask

   task automatic set_timing(input int s, input int c, input int d);
      S = s; C = c; D = d;
      sample_clks = CNTW'(s);
      convert_clks = CNTW'(c);
   endtask

   initial begin
      void'($urandom(32'h5EED_0A1C));
      for (int c = 0; c < NCH; c++) begin
         cdata[c] = '0; exp_res[c] = '0; exp_val[c] = 0; tref[c] = 0; tab[c] = 0;
      end
      for (int i = 0; i < LIST_LEN; i++) ent[i] = i;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(result_flat == '0, "R1 results zero", 0, 0);
      chk(result_valid == '0, "R1 valid zero", int'(result_valid), 0);
      chk(!busy && !scan_done && !conv_sample && !thr_irq, "R1 control idle",
          int'({busy, scan_done, conv_sample, thr_irq}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && result_valid == '0, "R1 idle after release", int'(busy), 0);

      // R2/R3/R4 basic scan, sample 0 acts as 1, late converter
      set_timing(0, 2, 5);
      ent = '{2, 0, 7, 4, 1, 3};
      for (int c = 0; c < NCH; c++) cdata[c] = 10'(c * 97 + 11);
      run_scan(4, 0, "R2 basic results");

      // R8: first conversions after enabling raise no interrupt
      thresh = 10'd300;
      set_thr(1);
      run_scan(6, 0, "R8 first pass results");
      chk(n_irq == 0, "R8 no interrupt on first result", n_irq, 0);

      // R7 directed crossings on channel 5
      ent = '{5, 5, 5, 5, 5, 5};
      set_timing(2, 7, 1);
      cdata[5] = 10'd100;
      run_scan(1, 0, "R7 below");
      cdata[5] = 10'd600;
      run_scan(1, 0, "R7 rise");
      chk(n_irq == 1 && obs_idir[0] == 1, "R7 rising crossing", obs_idir[0], 1);
      cdata[5] = 10'd50;
      run_scan(1, 0, "R7 fall");
      chk(n_irq == 1 && obs_idir[0] == 0, "R7 falling crossing", obs_idir[0], 0);

      // R7 mode off: a crossing gives nothing
      set_thr(0);
      cdata[5] = 10'd900;
      run_scan(1, 0, "R7 mode off results");
      chk(n_irq == 0, "R7 no interrupt when disabled", n_irq, 0);
      set_thr(1);

      // R5 offset saturation
      ent = '{0, 1, 2, 3, 4, 5};
      zero_off = 10'd1000;
      for (int c = 0; c < NCH; c++) cdata[c] = 10'(c * 100 + 50);
      run_scan(6, 0, "R5 clamped results");
      chk(result_flat[0 +: 10] == 10'd0, "R5 clamp to zero", int'(result_flat[0 +: 10]), 0);

      // R6 8-bit narrowing at full scale
      zero_off = 10'd0;
      res8 = 1'b1;
      cdata[3] = 10'h3FF;
      run_scan(6, 0, "R6 narrow results");
      chk(result_flat[30 +: 10] == 10'd255, "R6 full scale narrow", int'(result_flat[30 +: 10]), 255);
      res8 = 1'b0;

      // R2 length clamps: zero acts as one, over depth acts as depth
      set_timing(15, 15, 3);
      run_scan(0, 0, "R2 zero length");
      set_timing(1, 0, 6);
      run_scan(7, 0, "R2 over depth");

      // R11 go while busy ignored
      ent = '{6, 1, 6, 2, 0, 7};
      run_scan(5, 1, "R11 results");

      // R10 continuous restart
      begin
         int guard;
         set_thr(0);
         set_timing(1, 1, 2);
         ent = '{5, 1, 4, 0, 0, 0};
         load_list(3);
         model_pass(3);
         n_conv = 0;
         continuous = 1'b1;
         @(negedge clk);
         scan_go = 1'b1;
         @(negedge clk);
         scan_go = 1'b0;
         guard = 0;
         while (n_conv < 4 && guard < 2000) begin
            @(negedge clk);
            guard++;
         end
         chk(seq[3] == 5, "R10 restart at entry 0", seq[3], 5);
         chk(scan_done == 1'b1, "R9 done set after first pass", int'(scan_done), 1);
         continuous = 1'b0;
         guard = 0;
         while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
         end
         repeat (2) @(negedge clk);
         chk(n_conv == 6, "R10 stop at end of pass", n_conv, 6);
         check_results("R10 results");
         set_thr(1);
      end

      // constrained random scans
      for (int t = 0; t < 40; t++) begin
         int len;
         set_timing(int'($urandom % 6), int'($urandom % 8), 1 + int'($urandom % 6));
         len = 1 + int'($urandom % LIST_LEN);
         for (int i = 0; i < LIST_LEN; i++) ent[i] = int'($urandom % NCH);
         for (int c = 0; c < NCH; c++) cdata[c] = 10'($urandom);
         zero_off = (($urandom % 4) == 0) ? 10'($urandom) : 10'($urandom % 64);
         res8 = 1'($urandom);
         thresh = 10'($urandom);
         run_scan(len, 0, res8 ? "R6 random results" : "R5 random results");
      end

      finish_up();
   end

endmodule